// File: doc/BRIEF.md
# Conditional Execution Gate

This block decides, for every instruction slot, whether the instruction may execute. It compares the instruction's 4-bit condition field against the current negative (N), zero (Z), carry (C) and overflow (V) flags. It produces a pass indication and a gated valid strobe that feeds the execute stage.

The block also holds the flags in a small register. An instruction that executes can carry a flag update from the ALU into that register. The new flags take effect on the next clock edge, so the instruction in the following cycle is tested against them. An instruction whose condition fails leaves the register untouched.

The condition codes come in complementary pairs. An odd code is the exact inverse of the even code just below it. The hardware evaluates eight base tests and inverts the selected one with the lowest bit of the code.

Top module: `cc_gate_top`

## Requirements
- R1: Code 0 passes when Z=1, and code 1 passes when Z=0.
- R2: Code 2 passes when C=1, and code 3 passes when C=0.
- R3: Code 4 passes when N=1, and code 5 passes when N=0.
- R4: Code 6 passes when V=1, and code 7 passes when V=0.
- R5: Code 8 passes when C=1 and Z=0. Code 9 passes when Z=1 or C=0.
- R6: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R7: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R8: Code 14 passes for every flag value, and code 15 passes for none.
- R9: `exec_valid` is high exactly when `instr_valid` and `pass` are both high. `pass` follows the condition even when no instruction is presented.
- R10: After reset, `flags_out` is 0000. The bit order is N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R11: If `instr_valid`, `pass` and `flag_we` are all high in a cycle, `flags_out` equals that cycle's `flag_in` after the clock edge. The instruction in the next cycle is tested against the new value.
- R12: If any of `instr_valid`, `pass` or `flag_we` is low in a cycle, `flags_out` keeps its value across the clock edge. This covers a failed condition, an empty slot and a cleared write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is present in this slot |
| cond_code | input | 4 | Condition field of the instruction |
| flag_we | input | 1 | The instruction writes the flags |
| flag_in | input | 4 | New flag value {N,Z,C,V} from the ALU |
| pass | output | 1 | The condition holds for the current flags |
| exec_valid | output | 1 | Instruction valid gated by pass |
| flags_out | output | 4 | Held flags {N,Z,C,V} |

## Verification
Every one of the 16 flag values is loaded through the normal write path, and all 16 condition codes are then tested against it. This separates each code from its partner and catches any swapped flag bit or wrong compound term.

Separate scenarios cover the following cases:
- An empty slot, which must show pass but no `exec_valid`.
- A failing instruction that asserts `flag_we`, whose write must be dropped.
- A valid instruction with `flag_we` low.
- A write followed directly by a dependent test, which shows the one-cycle visibility.

// File: rtl/cc_gate_pkg.sv
package cc_gate_pkg;

    localparam int COND_W = 4;
    localparam int FLAG_W = 4;
    localparam int PAIRS  = 1 << (COND_W - 1);

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Base tests for the even code of each pair; the odd code inverts it.
    typedef enum logic [COND_W-2:0] {
        PAIR_ZERO   = 3'd0,
        PAIR_CARRY  = 3'd1,
        PAIR_NEG    = 3'd2,
        PAIR_OVF    = 3'd3,
        PAIR_UHIGH  = 3'd4,
        PAIR_SGE    = 3'd5,
        PAIR_SGT    = 3'd6,
        PAIR_ALWAYS = 3'd7
    } pair_e;

endpackage

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
    import cc_gate_pkg::*;
(
    input  logic [COND_W-1:0] cond_code,
    input  flags_t            flags,
    output logic              pass
);

    logic [PAIRS-1:0] base_ok;

    for (genvar gi = 0; gi < PAIRS; gi++) begin : g_pair
        always_comb begin
            case (pair_e'(gi))
                PAIR_ZERO:   base_ok[gi] = flags.z;
                PAIR_CARRY:  base_ok[gi] = flags.c;
                PAIR_NEG:    base_ok[gi] = flags.n;
                PAIR_OVF:    base_ok[gi] = flags.v;
                PAIR_UHIGH:  base_ok[gi] = flags.c & ~flags.z;
                PAIR_SGE:    base_ok[gi] = ~(flags.n ^ flags.v);
                PAIR_SGT:    base_ok[gi] = ~flags.z & ~(flags.n ^ flags.v);
                default:     base_ok[gi] = 1'b1;
            endcase
        end
    end

    always_comb begin
        pass = base_ok[cond_code[COND_W-1:1]] ^ cond_code[0];
    end

endmodule

// File: rtl/cc_flag_hold.sv
module cc_flag_hold
    import cc_gate_pkg::*;
#(
    parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  flags_t wr_flags,
    output flags_t flags
);

    typedef struct packed {
        flags_t held;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.held = wr_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.held <= flags_t'(RESET_FLAGS);
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.held;

endmodule

// File: rtl/cc_gate_top.sv
module cc_gate_top
    import cc_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [COND_W-1:0] cond_code,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    output logic              pass,
    output logic              exec_valid,
    output logic [FLAG_W-1:0] flags_out
);

    flags_t cur_flags;
    logic   cond_ok;
    logic   commit_flags;

    cc_cond_eval u_eval (
        .cond_code (cond_code),
        .flags     (cur_flags),
        .pass      (cond_ok)
    );

    always_comb begin
        commit_flags = instr_valid & cond_ok & flag_we;
    end

    cc_flag_hold #(
        .RESET_FLAGS ('0)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit_flags),
        .wr_flags (flags_t'(flag_in)),
        .flags    (cur_flags)
    );

    assign pass       = cond_ok;
    assign exec_valid = instr_valid & cond_ok;
    assign flags_out  = cur_flags;

endmodule

// File: rtl/cc_gate_chk.sv
module cc_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [3:0] cond_code,
    input logic       flag_we,
    input logic [3:0] flag_in,
    input logic       pass,
    input logic       exec_valid,
    input logic [3:0] flags_out
);

    assert_zero_test_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd0) |-> (pass == flags_out[2]));

    assert_sign_ge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd10) |-> (pass == (flags_out[3] == flags_out[0])));

    assert_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cond_code == 4'd14) |-> exec_valid);

    assert_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd15) |-> !pass && !exec_valid);

    assert_gate_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> instr_valid);

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && pass && flag_we) |=> (flags_out == $past(flag_in)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && pass && flag_we) |=> $stable(flags_out));

endmodule

bind cc_gate_top cc_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .cond_code   (cond_code),
    .flag_we     (flag_we),
    .flag_in     (flag_in),
    .pass        (pass),
    .exec_valid  (exec_valid),
    .flags_out   (flags_out)
);

// File: tb/cc_gate_top_tb_top.sv
module cc_gate_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       instr_valid;
    logic [3:0] cond_code;
    logic       flag_we;
    logic [3:0] flag_in;
    logic       pass;
    logic       exec_valid;
    logic [3:0] flags_out;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cc_gate_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .cond_code   (cond_code),
        .flag_we     (flag_we),
        .flag_in     (flag_in),
        .pass        (pass),
        .exec_valid  (exec_valid),
        .flags_out   (flags_out)
    );

    // Reference model of the condition table; flag order {N,Z,C,V}.
    function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return z || !cy;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c[3:1])
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        instr_valid = 1'b0;
        cond_code   = 4'd14;
        flag_we     = 1'b0;
        flag_in     = 4'd0;
    endtask

    // Write flags with an always-pass instruction; new value after the edge.
    task automatic load_flags(input logic [3:0] f);
        @(negedge clk);
        instr_valid = 1'b1;
        cond_code   = 4'd14;
        flag_we     = 1'b1;
        flag_in     = f;
        @(negedge clk);
        idle();
        #1;
        check("R11", "loaded flags", flags_out, f);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", "flags after reset", flags_out, 4'b0000);
        cond_code = 4'd0;
        #1;
        check("R1", "EQ after reset", {3'b0, pass}, 4'd0);
        cond_code = 4'd1;
        #1;
        check("R1", "NE after reset", {3'b0, pass}, 4'd1);
    endtask

    // R1..R8 and R9: all codes against all flag values.
    task automatic t_sweep();
        for (int f = 0; f < 16; f++) begin
            load_flags(4'(f));
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                instr_valid = 1'b1;
                flag_we     = 1'b0;
                cond_code   = 4'(c);
                #2;
                check(req_of(4'(c)), "pass", {3'b0, pass},
                      {3'b0, ref_pass(4'(c), 4'(f))});
                check("R9", "exec_valid", {3'b0, exec_valid},
                      {3'b0, ref_pass(4'(c), 4'(f))});
            end
            idle();
        end
    endtask

    task automatic t_empty_slot();
        load_flags(4'b0100);
        @(negedge clk);
        instr_valid = 1'b0;
        cond_code   = 4'd0;
        #2;
        check("R9", "pass on empty slot", {3'b0, pass}, 4'd1);
        check("R9", "exec_valid on empty slot", {3'b0, exec_valid}, 4'd0);
        flag_we = 1'b1;
        flag_in = 4'b1011;
        @(negedge clk);
        idle();
        #1;
        check("R12", "empty slot write dropped", flags_out, 4'b0100);
    endtask

    task automatic t_failed_write();
        load_flags(4'b0000);
        @(negedge clk);
        instr_valid = 1'b1;
        cond_code   = 4'd0;
        flag_we     = 1'b1;
        flag_in     = 4'b1111;
        #2;
        check("R12", "EQ fails with Z=0", {3'b0, exec_valid}, 4'd0);
        @(negedge clk);
        idle();
        #1;
        check("R12", "failed instr keeps flags", flags_out, 4'b0000);
    endtask

    task automatic t_we_low();
        load_flags(4'b0010);
        @(negedge clk);
        instr_valid = 1'b1;
        cond_code   = 4'd14;
        flag_we     = 1'b0;
        flag_in     = 4'b1101;
        @(negedge clk);
        idle();
        #1;
        check("R12", "flag_we low keeps flags", flags_out, 4'b0010);
    endtask

    task automatic t_back_to_back();
        load_flags(4'b0000);
        @(negedge clk);
        instr_valid = 1'b1;
        cond_code   = 4'd1;
        flag_we     = 1'b1;
        flag_in     = 4'b0100;
        #2;
        check("R11", "NE passes before write", {3'b0, exec_valid}, 4'd1);
        @(negedge clk);
        cond_code = 4'd0;
        flag_we   = 1'b1;
        flag_in   = 4'b1001;
        #2;
        check("R11", "EQ sees Z written last cycle", {3'b0, exec_valid}, 4'd1);
        @(negedge clk);
        cond_code = 4'd11;
        flag_we   = 1'b0;
        #2;
        check("R11", "flags chained", flags_out, 4'b1001);
        check("R11", "LT with N=1 V=1", {3'b0, pass}, 4'd0);
        idle();
    endtask

    initial begin
        #1_000_000;
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_empty_slot();
        t_failed_write();
        t_we_low();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule